// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter

This block keeps the wall-clock time and calendar date of a real-time clock. It advances them by one second on each accepted pulse of a one-second tick. The count is held internally in plain binary. Each output byte is formed on the way out in the encoding selected by two control bits: packed BCD or binary, and 12-hour or 24-hour hours. Flipping either bit therefore changes the presented form at once and never disturbs the count itself.

Software or a bus front end loads the fields one at a time through a write strobe, a field selector and a data byte. The byte is read in whatever encoding is selected at that moment. A halt bit freezes the count while a consistent set of fields is being loaded. Each accepted tick produces a one-cycle completion pulse. A separate century byte, always in BCD, extends the two-digit year.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes each count 0 to 59. An accepted tick adds one second. Going from 59 to 0 carries one into the next field up.
- R2: In 24-hour mode (`mode_24h`=1) the hour byte counts 0 to 23. Going from 23 to 0 carries one day into the date fields.
- R3: In 12-hour mode (`mode_24h`=0) the hour byte shows 1 to 12 in bits 6:0, and bit 7 is set for PM. Internal hour 0 shows as 12 with bit 7 clear. Hours 1 to 11 show unchanged with bit 7 clear. Hour 12 shows as 12 with bit 7 set. Hours 13 to 23 show as hour minus 12 with bit 7 set.
- R4: With `fmt_bin`=1 every field except the century is presented in plain binary. With `fmt_bin`=0 it is presented in packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. A change of `fmt_bin` or `mode_24h` alters the outputs in the same cycle and leaves the count unchanged.
- R5: Day of week runs 1 to 7 (Sunday = 1) and goes from 7 back to 1 at midnight. Day of month goes back to 1 after the last day of the month. That last day is 30 for months 4, 6, 9 and 11, 31 for the other months except February, and for February 29 when the year is divisible by 4 and 28 otherwise.
- R6: Month runs 1 to 12 and carries into the year after 12. Year runs 0 to 99. The century byte is always in BCD and goes up by one when the year goes from 99 to 0, with the century itself wrapping from 99 to 00.
- R7: While `halt` is 1, ticks are ignored: no field changes and no completion pulse is produced. Writes are still accepted.
- R8: A tick sampled high, with `halt` low and no write, advances the fields at that clock edge. `upd_done` is high for exactly the following cycle and at no other time.
- R9: A write loads one field on the clock edge where `wr_en` is high. `wr_sel` selects the field: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century. `wr_data` is decoded in the current encoding. In 12-hour mode, bit 7 of an hour write marks PM and bits 6:0 must give 1 to 12. The century is always decoded as BCD. A write is rejected and the field left unchanged if a BCD nibble is above 9 or if the decoded value is outside the field's range. The ranges are 0..59, hours 0..23 (or 1..12 in 12-hour mode), 1..7, 1..31, 1..12, 0..99 and 0..99.
- R10: A write strobe in the same cycle as a tick takes priority. The write is applied, the advance is skipped and no completion pulse follows.
- R11: After reset the count is 00:00:00, day of week 1, day 1, month 1, year 00, century 20, and `upd_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second tick, one cycle wide |
| halt | input | 1 | Freeze the count while 1 |
| fmt_bin | input | 1 | 1 = binary presentation, 0 = packed BCD |
| mode_24h | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM flag |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector for writes |
| wr_data | input | 8 | Field value in current encoding |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours (bit 7 = PM in 12-hour mode) |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |
| cent_o | output | 8 | Century, BCD |
| upd_done | output | 1 | One-cycle pulse after an accepted tick |

## Verification
A tick or write sampled at one rising edge changes the field outputs right after that edge. `upd_done` rises at the same edge and falls at the next one. The encoding bits act with no register in between, so a change in them shows in the same cycle. The bench keeps a behavioural reference model that is updated at each rising edge from the inputs sampled there. It compares every output against that model at each falling edge, after the edge's effects have settled and before new inputs are driven. Every latency above is therefore checked in the exact cycle where it is due.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned VAL_W   = 7;
    localparam int unsigned SEL_W   = 3;
    localparam logic [6:0]  CENT_RST = 7'd20;

    typedef enum logic [SEL_W-1:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_WDAY = 3'd3,
        F_MDAY = 3'd4,
        F_MON  = 3'd5,
        F_YEAR = 3'd6,
        F_CENT = 3'd7
    } field_e;

    typedef struct packed {
        logic [6:0] cent;
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;

    // binary 0..99 to packed BCD
    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v - tens * 7'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
        case (m)
            4'd2:                      return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_wrdec.sv
module rtc_cal_wrdec
    import rtc_cal_pkg::*;
(
    input  logic        fmt_bin,
    input  logic        mode_24h,
    input  field_e      sel,
    input  logic [7:0]  data,
    output logic [6:0]  val,
    output logic        ok
);

    logic       h12;
    logic       use_bcd;
    logic       nib_ok;
    logic [7:0] src;
    logic [7:0] num;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] base12;

    always_comb begin
        h12     = (sel == F_HOUR) && !mode_24h;
        use_bcd = !fmt_bin || (sel == F_CENT);
        src     = h12 ? {1'b0, data[6:0]} : data;

        if (use_bcd) begin
            nib_ok = (src[7:4] <= 4'd9) && (src[3:0] <= 4'd9);
            num    = {4'd0, src[7:4]} * 8'd10 + {4'd0, src[3:0]};
        end else begin
            nib_ok = 1'b1;
            num    = src;
        end

        case (sel)
            F_SEC, F_MIN:    begin lo = 8'd0; hi = 8'd59; end
            F_HOUR:          begin lo = h12 ? 8'd1 : 8'd0; hi = h12 ? 8'd12 : 8'd23; end
            F_WDAY:          begin lo = 8'd1; hi = 8'd7;  end
            F_MDAY:          begin lo = 8'd1; hi = 8'd31; end
            F_MON:           begin lo = 8'd1; hi = 8'd12; end
            default:         begin lo = 8'd0; hi = 8'd99; end
        endcase

        ok = nib_ok && (num >= lo) && (num <= hi);

        base12 = (num == 8'd12) ? 8'd0 : num;
        if (h12)
            val = base12[6:0] + (data[7] ? 7'd12 : 7'd0);
        else
            val = num[6:0];
    end

endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
    import rtc_cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        halt,
    input  logic        wr_en,
    input  field_e      wr_sel,
    input  logic [6:0]  wr_val,
    input  logic        wr_ok,
    output tod_t        tod_q,
    output logic        done_q
);

    tod_t tod_adv;
    tod_t tod_n;
    logic adv;

    assign adv = tick && !halt && !wr_en;

    // one-second advance with full carry chain
    always_comb begin
        tod_adv = tod_q;
        if (tod_q.sec >= 6'd59) begin
            tod_adv.sec = 6'd0;
            if (tod_q.min >= 6'd59) begin
                tod_adv.min = 6'd0;
                if (tod_q.hour >= 5'd23) begin
                    tod_adv.hour = 5'd0;
                    tod_adv.wday = (tod_q.wday >= 3'd7) ? 3'd1 : tod_q.wday + 3'd1;
                    if (tod_q.mday >= month_len(tod_q.mon, tod_q.year)) begin
                        tod_adv.mday = 5'd1;
                        if (tod_q.mon >= 4'd12) begin
                            tod_adv.mon = 4'd1;
                            if (tod_q.year >= 7'd99) begin
                                tod_adv.year = 7'd0;
                                tod_adv.cent = (tod_q.cent >= 7'd99) ? 7'd0 : tod_q.cent + 7'd1;
                            end else begin
                                tod_adv.year = tod_q.year + 7'd1;
                            end
                        end else begin
                            tod_adv.mon = tod_q.mon + 4'd1;
                        end
                    end else begin
                        tod_adv.mday = tod_q.mday + 5'd1;
                    end
                end else begin
                    tod_adv.hour = tod_q.hour + 5'd1;
                end
            end else begin
                tod_adv.min = tod_q.min + 6'd1;
            end
        end else begin
            tod_adv.sec = tod_q.sec + 6'd1;
        end
    end

    always_comb begin
        tod_n = tod_q;
        if (wr_en) begin
            if (wr_ok) begin
                case (wr_sel)
                    F_SEC:   tod_n.sec  = wr_val[5:0];
                    F_MIN:   tod_n.min  = wr_val[5:0];
                    F_HOUR:  tod_n.hour = wr_val[4:0];
                    F_WDAY:  tod_n.wday = wr_val[2:0];
                    F_MDAY:  tod_n.mday = wr_val[4:0];
                    F_MON:   tod_n.mon  = wr_val[3:0];
                    F_YEAR:  tod_n.year = wr_val;
                    default: tod_n.cent = wr_val;
                endcase
            end
        end else if (adv) begin
            tod_n = tod_adv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tod_q      <= '0;
            tod_q.wday <= 3'd1;
            tod_q.mday <= 5'd1;
            tod_q.mon  <= 4'd1;
            tod_q.cent <= CENT_RST;
            done_q     <= 1'b0;
        end else begin
            tod_q  <= tod_n;
            done_q <= adv;
        end
    end

    assert_time_range_R1: assert property (@(posedge clk) disable iff (rst)
        (tod_q.sec < 6'd60) && (tod_q.min < 6'd60));

    assert_hour_range_R2: assert property (@(posedge clk) disable iff (rst)
        tod_q.hour < 5'd24);

    assert_date_range_R5: assert property (@(posedge clk) disable iff (rst)
        (tod_q.wday >= 3'd1) && (tod_q.mday >= 5'd1) &&
        (tod_q.mon >= 4'd1) && (tod_q.mon <= 4'd12));

    assert_year_range_R6: assert property (@(posedge clk) disable iff (rst)
        (tod_q.year < 7'd100) && (tod_q.cent < 7'd100));

    assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (halt && !wr_en) |=> $stable(tod_q));

    assert_done_cause_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(tick && !halt && !wr_en));

    assert_sec_step_R1: assert property (@(posedge clk) disable iff (rst)
        (done_q && ($past(tod_q.sec) != 6'd59)) |-> (tod_q.sec == $past(tod_q.sec) + 6'd1));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tick) |=> !done_q);

endmodule

// File: rtl/rtc_cal_fmt.sv
module rtc_cal_fmt
    import rtc_cal_pkg::*;
(
    input  tod_t        tod,
    input  logic        fmt_bin,
    input  logic        mode_24h,
    output logic [7:0]  sec_b,
    output logic [7:0]  min_b,
    output logic [7:0]  hour_b,
    output logic [7:0]  wday_b,
    output logic [7:0]  mday_b,
    output logic [7:0]  mon_b,
    output logic [7:0]  year_b,
    output logic [7:0]  cent_b
);

    function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    logic [6:0] h12;
    logic       pm;
    logic [7:0] h12_enc;

    always_comb begin
        pm = (tod.hour >= 5'd12);
        if (tod.hour == 5'd0)
            h12 = 7'd12;
        else if (tod.hour > 5'd12)
            h12 = {2'b00, tod.hour - 5'd12};
        else
            h12 = {2'b00, tod.hour};
        h12_enc = enc(h12, fmt_bin);

        sec_b  = enc({1'b0, tod.sec}, fmt_bin);
        min_b  = enc({1'b0, tod.min}, fmt_bin);
        hour_b = mode_24h ? enc({2'b00, tod.hour}, fmt_bin) : {pm, h12_enc[6:0]};
        wday_b = enc({4'd0, tod.wday}, fmt_bin);
        mday_b = enc({2'b00, tod.mday}, fmt_bin);
        mon_b  = enc({3'd0, tod.mon}, fmt_bin);
        year_b = enc(tod.year, fmt_bin);
        cent_b = to_bcd(tod.cent);
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int unsigned DW = BYTE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_1hz,
    input  logic            halt,
    input  logic            fmt_bin,
    input  logic            mode_24h,
    input  logic            wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   sec_o,
    output logic [DW-1:0]   min_o,
    output logic [DW-1:0]   hour_o,
    output logic [DW-1:0]   wday_o,
    output logic [DW-1:0]   mday_o,
    output logic [DW-1:0]   mon_o,
    output logic [DW-1:0]   year_o,
    output logic [DW-1:0]   cent_o,
    output logic            upd_done
);

    localparam int unsigned PM_BIT = DW - 1;

    field_e           sel;
    logic [VAL_W-1:0] wr_val;
    logic             wr_ok;
    tod_t             tod;

    assign sel = field_e'(wr_sel);

    rtc_cal_wrdec u_dec (
        .fmt_bin  (fmt_bin),
        .mode_24h (mode_24h),
        .sel      (sel),
        .data     (wr_data[7:0]),
        .val      (wr_val),
        .ok       (wr_ok)
    );

    rtc_cal_core u_core (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_1hz),
        .halt   (halt),
        .wr_en  (wr_en),
        .wr_sel (sel),
        .wr_val (wr_val),
        .wr_ok  (wr_ok),
        .tod_q  (tod),
        .done_q (upd_done)
    );

    rtc_cal_fmt u_fmt (
        .tod      (tod),
        .fmt_bin  (fmt_bin),
        .mode_24h (mode_24h),
        .sec_b    (sec_o),
        .min_b    (min_o),
        .hour_b   (hour_o),
        .wday_b   (wday_o),
        .mday_b   (mday_o),
        .mon_b    (mon_o),
        .year_b   (year_o),
        .cent_b   (cent_o)
    );

    assert_h12_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        !mode_24h |-> (hour_o[PM_BIT-1:0] != '0));

    assert_bcd_digits_R4: assert property (@(posedge clk) disable iff (rst)
        !fmt_bin |-> ((sec_o[3:0] <= 4'd9) && (min_o[3:0] <= 4'd9) && (year_o[3:0] <= 4'd9)));

    assert_cent_bcd_R6: assert property (@(posedge clk) disable iff (rst)
        (cent_o[3:0] <= 4'd9) && (cent_o[7:4] <= 4'd9));

endmodule

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       halt = 1'b0;
    logic       fmt_bin = 1'b0;
    logic       mode_24h = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, cent_o;
    logic       upd_done;

    int n_cmp  = 0;
    int n_fail = 0;
    string cur_req = "R11";

    // reference model state (binary)
    int ms, mm, mh, mwd, mmd, mmo, my, mc;
    int mdone;

    always #5 clk = ~clk;

    rtc_calendar i_rtc_calendar (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .halt(halt),
        .fmt_bin(fmt_bin), .mode_24h(mode_24h), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o), .cent_o(cent_o),
        .upd_done(upd_done)
    );

    function automatic int days_of(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // decode a written byte; -1 = rejected (R9)
    function automatic int decode(int sel, int d, bit fb, bit m24);
        bit h12; bit ub; int s; int n;
        h12 = (sel == 2) && !m24;
        ub  = !fb || (sel == 7);
        s   = h12 ? d % 128 : d;
        if (ub) begin
            if (s / 16 > 9 || s % 16 > 9) return -1;
            n = (s / 16) * 10 + s % 16;
        end else n = s;
        case (sel)
            0, 1: if (n > 59) return -1;
            2: begin
                if (h12) begin
                    if (n < 1 || n > 12) return -1;
                    return (n % 12) + ((d >= 128) ? 12 : 0);
                end
                if (n > 23) return -1;
            end
            3: if (n < 1 || n > 7) return -1;
            4: if (n < 1 || n > 31) return -1;
            5: if (n < 1 || n > 12) return -1;
            default: if (n > 99) return -1;
        endcase
        return n;
    endfunction

    function automatic int bcd(int v);
        return (v / 10) * 16 + v % 10;
    endfunction

    function automatic int show(int v, bit fb);
        return fb ? v : bcd(v);
    endfunction

    function automatic int show_hour(int h, bit fb, bit m24);
        int v;
        if (m24) return show(h, fb);
        v = (h % 12 == 0) ? 12 : h % 12;
        return show(v, fb) + ((h >= 12) ? 128 : 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ms = 0; mm = 0; mh = 0; mwd = 1; mmd = 1; mmo = 1; my = 0; mc = 20;
            mdone = 0;
        end else begin
            mdone = 0;
            if (wr_en) begin
                int v;
                v = decode(int'(wr_sel), int'(wr_data), fmt_bin, mode_24h);
                if (v >= 0) begin
                    case (wr_sel)
                        3'd0: ms = v;  3'd1: mm = v;  3'd2: mh = v;  3'd3: mwd = v;
                        3'd4: mmd = v; 3'd5: mmo = v; 3'd6: my = v;  default: mc = v;
                    endcase
                end
            end else if (tick_1hz && !halt) begin
                mdone = 1;
                ms++;
                if (ms == 60) begin
                    ms = 0; mm++;
                    if (mm == 60) begin
                        mm = 0; mh++;
                        if (mh == 24) begin
                            mh = 0;
                            mwd = mwd % 7 + 1;
                            mmd++;
                            if (mmd > days_of(mmo, my)) begin
                                mmd = 1; mmo++;
                                if (mmo > 12) begin
                                    mmo = 1; my++;
                                    if (my == 100) begin my = 0; mc = (mc + 1) % 100; end
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic check(string f, string rq, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s/%s %s: actual %0h expected %0h at %0t", cur_req, rq, f, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("sec",  "R1", int'(sec_o),  show(ms, fmt_bin));
        check("min",  "R1", int'(min_o),  show(mm, fmt_bin));
        check("hour", "R3", int'(hour_o), show_hour(mh, fmt_bin, mode_24h));
        check("wday", "R5", int'(wday_o), show(mwd, fmt_bin));
        check("mday", "R5", int'(mday_o), show(mmd, fmt_bin));
        check("mon",  "R6", int'(mon_o),  show(mmo, fmt_bin));
        check("year", "R6", int'(year_o), show(my, fmt_bin));
        check("cent", "R6", int'(cent_o), bcd(mc));
        check("done", "R8", int'(upd_done), mdone);
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(int sel, int d);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(d);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic tick();
        tick_1hz = 1'b1;
        cyc();
        tick_1hz = 1'b0;
        cyc();
    endtask

    // load a full BCD time/date in 24h mode
    task automatic set_bcd(int h, int mi, int s, int wd, int md, int mo, int y);
        wr(2, h); wr(1, mi); wr(0, s); wr(3, wd); wr(4, md); wr(5, mo); wr(6, y);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        cur_req = "R11";
        cyc(); cyc();

        // R9 BCD 24h writes, R2 R5 R6 full rollover with century carry
        cur_req = "R9";
        set_bcd('h23, 'h59, 'h59, 'h07, 'h31, 'h12, 'h99);
        wr(7, 'h20);
        wr(0, 'h5A);              // R9 bad nibble, rejected
        wr(0, 'h60);              // R9 out of range, rejected
        wr(4, 'h00);              // R9 day 0 rejected
        cyc();
        cur_req = "R6";
        tick();
        cyc();

        // R4 encoding change acts at once without touching the count
        cur_req = "R4";
        wr(0, 'h47);
        fmt_bin = 1'b1; cyc(); cyc();
        wr(1, 45);                // binary write
        fmt_bin = 1'b0; cyc();

        // R5 February, non-leap and leap, and a 30-day month
        cur_req = "R5";
        set_bcd('h23, 'h59, 'h59, 'h03, 'h28, 'h02, 'h03);
        tick();
        set_bcd('h23, 'h59, 'h59, 'h03, 'h28, 'h02, 'h04);
        tick();
        set_bcd('h23, 'h59, 'h59, 'h03, 'h29, 'h02, 'h04);
        tick();
        set_bcd('h23, 'h59, 'h59, 'h05, 'h30, 'h04, 'h10);
        tick();

        // R3 12-hour presentation and writes
        cur_req = "R3";
        mode_24h = 1'b0;
        cyc();
        wr(2, 'h92);              // 12 PM -> hour 12
        wr(2, 'h12);              // 12 AM -> hour 0
        wr(2, 'h00);              // rejected in 12h mode
        for (int i = 0; i < 26; i++) begin
            wr(1, 'h59); wr(0, 'h59);
            tick();
        end
        mode_24h = 1'b1; cyc();
        mode_24h = 1'b0; cyc();

        // R1 R8 long run, binary 12h mode
        cur_req = "R1";
        fmt_bin = 1'b1;
        for (int i = 0; i < 4000; i++) tick();
        mode_24h = 1'b1;
        for (int i = 0; i < 200; i++) tick();
        fmt_bin = 1'b0;

        // R7 halt: ticks ignored, writes taken
        cur_req = "R7";
        halt = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        wr(0, 'h30);
        tick();
        halt = 1'b0;
        tick();

        // R10 write in the same cycle as a tick
        cur_req = "R10";
        tick_1hz = 1'b1;
        wr(1, 'h10);
        tick_1hz = 1'b0;
        cyc();
        tick();

        cur_req = "R11";
        rst = 1'b1; cyc(); rst = 1'b0; cyc(); cyc();

        finish_run();
    end

endmodule